// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Clock-Factor Sampling

This block receives asynchronous serial characters on one input line. It hands each character to a host as a parallel byte. An external receive clock paces the line. That clock runs at one, sixteen or sixty-four times the bit rate, and a mode word selects which. The receive clock and the serial line both pass through synchronizers into the system clock domain. Each rising edge of the synchronized receive clock is one sampling tick.

When the block sees the line go low, it checks the line again half a bit later before it accepts a start bit. It then samples each data bit in the middle of its bit time. Data bits arrive least significant bit first. The mode word also sets the character length (5 to 8 bits) and the parity (none, odd or even).

Bits collect in a shift register. A finished character then moves into a separate holding buffer, so the next character can arrive while the host still reads the last one. A ready output stays high until the host reads the buffer. A status word reports parity, framing and overrun errors. These error flags stay set until the host clears them with a command write. The host uses active-low read and write strobes. A select input chooses between the data path and the control/status path.

Top module: `serial_rx_unit`

## Requirements
- R1: After reset, ready is 0, the status word reads 0x00 and the data buffer reads 0x00. The mode word is 0x00, which means 1x factor, 5-bit characters and no parity.
- R2: Bits [1:0] of the mode word select the receive-clock factor: 00 is 1x, 01 is 16x, and 10 or 11 is 64x. In 16x and 64x modes, each data bit is sampled when the tick counter reaches the factor, which is mid-bit. In 1x mode, every tick after the start tick samples one bit.
- R3: In 16x and 64x modes, the first low tick seen while idle is checked again factor/2 ticks later. If the line is high at that check, the block goes back to idle and delivers no character.
- R4: Mode bits [3:2] plus 5 give the character length. Data bits arrive least significant bit first. The character is stored right-aligned, with the unused upper bits read as 0.
- R5: The holding buffer keeps the previous character while the next one shifts in. A data read returns the held character.
- R6: A finished character sets ready. A falling edge of rd_n_i with cmd_sel_i=0 clears it. A status read (cmd_sel_i=1) leaves ready unchanged.
- R7: Mode bit [4] enables parity and mode bit [5] selects even parity (1) or odd parity (0). A mismatch sets status bit 1.
- R8: A low stop-bit sample sets status bit 3. The character is still delivered.
- R9: If a character finishes while ready is still set, status bit 2 (overrun) is set and the new character replaces the old one.
- R10: If a data read and a character completion happen in the same cycle, ready stays 1, no overrun is flagged and the buffer takes the new character.
- R11: A write with cmd_sel_i=1 goes to the mode word when wdata_i[7]=0. When wdata_i[7:6]=11, the write clears the three error flags and leaves ready and the buffer unchanged. A write with cmd_sel_i=0 has no effect.
- R12: Error flags are sticky. They survive data reads and later good characters until a clear command.
- R13: The status word is {4'b0, framing, overrun, parity, ready}, from bit 7 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high synchronous reset; forces the block idle |
| rx_clk_i | input | 1 | Receive clock at 1x/16x/64x the bit rate |
| rxd_i | input | 1 | Serial line; idles high |
| cmd_sel_i | input | 1 | 1 selects control/status, 0 selects data |
| rd_n_i | input | 1 | Active-low read strobe; acts on its falling edge |
| wr_n_i | input | 1 | Active-low write strobe; acts on its falling edge |
| wdata_i | input | 8 | Write data for the mode word or a command |
| rdata_o | output | 8 | Holding buffer or status word, as chosen by cmd_sel_i |
| ready_o | output | 1 | High while the buffer holds an unread character |

## Verification
Two events can land on the same clock edge: a host data read that clears ready, and a character completion that sets it. The bench places a read strobe on exactly the stop-bit sampling tick of a second character. The first character is still unread at that point. The value captured during the strobe must be the first character. Afterwards, ready must stay high, the overrun bit must stay clear and the buffer must hold the second character. A separate run with no read during the second character must set the overrun bit. Together the two runs confirm the block distinguishes these cases.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    localparam int CHAR_W  = 8;
    localparam int MIN_LEN = 5;
    localparam int FCT_MID = 16;
    localparam int FCT_TOP = 64;
    localparam int CNT_W   = $clog2(FCT_TOP + 1);
    localparam int NBIT_W  = $clog2(CHAR_W);

    localparam logic [1:0] FCT_CODE_X1  = 2'b00;
    localparam logic [1:0] FCT_CODE_X16 = 2'b01;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic       even_par;
        logic       par_en;
        logic [1:0] len_code;
        logic [1:0] fct;
    } rx_mode_t;

    function automatic logic [CNT_W-1:0] factor_of(input logic [1:0] code);
        case (code)
            FCT_CODE_X1:  factor_of = CNT_W'(1);
            FCT_CODE_X16: factor_of = CNT_W'(FCT_MID);
            default:      factor_of = CNT_W'(FCT_TOP);
        endcase
    endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr_d, sr_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sr_d = d;
        end else begin : g_chain
            always_comb sr_d = {sr_q[STAGES-2:0], d};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) sr_q <= {STAGES{RST_VAL}};
        else     sr_q <= sr_d;
    end

    assign q = sr_q[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
module rx_framer
    import serial_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rxclk_s,
    input  logic              rxd_s,
    input  rx_mode_t          mode_i,
    output logic              done_o,
    output logic [CHAR_W-1:0] char_o,
    output logic              perr_o,
    output logic              ferr_o
);
    typedef struct packed {
        rx_state_e          st;
        logic [CNT_W-1:0]   cnt;
        logic [NBIT_W-1:0]  nbit;
        logic [CHAR_W-1:0]  sh;
        logic               par;
        logic               par_bad;
        logic               ck_prev;
    } framer_t;

    framer_t q, n;
    logic [CNT_W-1:0]  fval, half, cnt_inc;
    logic [NBIT_W-1:0] sft;
    logic tick, sample, last;

    always_comb begin
        n       = q;
        done_o  = 1'b0;
        perr_o  = 1'b0;
        ferr_o  = 1'b0;
        fval    = factor_of(mode_i.fct);
        half    = fval >> 1;
        tick    = rxclk_s & ~q.ck_prev;
        cnt_inc = q.cnt + 1'b1;
        sample  = (cnt_inc == fval);
        last    = (q.nbit == NBIT_W'(MIN_LEN - 1) + NBIT_W'(mode_i.len_code));
        n.ck_prev = rxclk_s;
        if (tick) begin
            case (q.st)
                RX_IDLE: begin
                    if (!rxd_s) begin
                        n.cnt     = '0;
                        n.nbit    = '0;
                        n.par     = 1'b0;
                        n.par_bad = 1'b0;
                        n.st      = (mode_i.fct == FCT_CODE_X1) ? RX_DATA : RX_START;
                    end
                end
                RX_START: begin
                    n.cnt = cnt_inc;
                    if (cnt_inc == half) begin
                        n.cnt = '0;
                        n.st  = rxd_s ? RX_IDLE : RX_DATA;
                    end
                end
                RX_DATA: begin
                    n.cnt = sample ? '0 : cnt_inc;
                    if (sample) begin
                        n.sh   = {rxd_s, q.sh[CHAR_W-1:1]};
                        n.par  = q.par ^ rxd_s;
                        n.nbit = q.nbit + 1'b1;
                        if (last) n.st = mode_i.par_en ? RX_PAR : RX_STOP;
                    end
                end
                RX_PAR: begin
                    n.cnt = sample ? '0 : cnt_inc;
                    if (sample) begin
                        n.par_bad = q.par ^ rxd_s ^ ~mode_i.even_par;
                        n.st      = RX_STOP;
                    end
                end
                RX_STOP: begin
                    n.cnt = sample ? '0 : cnt_inc;
                    if (sample) begin
                        done_o = 1'b1;
                        ferr_o = ~rxd_s;
                        perr_o = q.par_bad;
                        n.st   = RX_IDLE;
                    end
                end
                default: n.st = RX_IDLE;
            endcase
        end
    end

    assign sft    = NBIT_W'(CHAR_W - MIN_LEN) - NBIT_W'(mode_i.len_code);
    assign char_o = q.sh >> sft;

    always_ff @(posedge clk) begin
        if (rst) begin
            q         <= '0;
            q.st      <= RX_IDLE;
        end else begin
            q <= n;
        end
    end

    AST_RECHECK_LOW: assert property (@(posedge clk) disable iff (rst)
        (q.st == RX_DATA && $past(q.st) == RX_START) |-> !$past(rxd_s)); // R3
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        (q.st != RX_IDLE) |-> (q.cnt < fval)); // R2
    AST_DONE_SPACED: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R2
endmodule

// File: rtl/rx_host_port.sv
module rx_host_port
    import serial_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_sel_i,
    input  logic              rd_n_i,
    input  logic              wr_n_i,
    input  logic [7:0]        wdata_i,
    input  logic              done_i,
    input  logic [CHAR_W-1:0] char_i,
    input  logic              perr_i,
    input  logic              ferr_i,
    output rx_mode_t          mode_o,
    output logic [CHAR_W-1:0] rdata_o,
    output logic              ready_o
);
    typedef struct packed {
        rx_mode_t          mode;
        logic [CHAR_W-1:0] hold;
        logic              ready;
        logic              pe;
        logic              oe;
        logic              fe;
        logic              rd_prev;
        logic              wr_prev;
    } host_t;

    host_t q, n;
    logic rd_evt, rd_data, wr_evt, mode_wr, clr;

    always_comb begin
        n         = q;
        n.rd_prev = rd_n_i;
        n.wr_prev = wr_n_i;
        rd_evt    = ~rd_n_i & q.rd_prev;
        rd_data   = rd_evt & ~cmd_sel_i;
        wr_evt    = ~wr_n_i & q.wr_prev;
        mode_wr   = wr_evt & cmd_sel_i & ~wdata_i[7];
        clr       = wr_evt & cmd_sel_i & wdata_i[7] & wdata_i[6];
        if (mode_wr) n.mode = rx_mode_t'(wdata_i[5:0]);
        if (clr) begin
            n.pe = 1'b0;
            n.oe = 1'b0;
            n.fe = 1'b0;
        end
        if (rd_data) n.ready = 1'b0;
        if (done_i) begin
            n.hold  = char_i;
            n.ready = 1'b1;
            if (q.ready && !rd_data) n.oe = 1'b1;
            if (perr_i) n.pe = 1'b1;
            if (ferr_i) n.fe = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q         <= '0;
            q.rd_prev <= 1'b1;
            q.wr_prev <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign mode_o  = q.mode;
    assign ready_o = q.ready;
    assign rdata_o = cmd_sel_i ? {{(CHAR_W-4){1'b0}}, q.fe, q.oe, q.pe, q.ready} : q.hold;

    AST_READY_SET: assert property (@(posedge clk) disable iff (rst)
        done_i |=> q.ready); // R6
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_data && !done_i) |=> !q.ready); // R6
    AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(q.oe) |-> ($past(q.ready) && $past(done_i))); // R9
    AST_COLLIDE: assert property (@(posedge clk) disable iff (rst)
        (done_i && rd_data && !clr) |=> (q.ready && $stable(q.oe))); // R10
    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clr && !done_i) |=> (!q.pe && !q.oe && !q.fe)); // R11
    AST_BUF_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done_i |=> $stable(q.hold)); // R5
endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
    import serial_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_clk_i,
    input  logic       rxd_i,
    input  logic       cmd_sel_i,
    input  logic       rd_n_i,
    input  logic       wr_n_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] rdata_o,
    output logic       ready_o
);
    logic              rxclk_s, rxd_s, done, perr, ferr;
    logic [CHAR_W-1:0] char_w;
    rx_mode_t          mode;

    rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_clk_sync (
        .clk(clk), .rst(rst), .d(rx_clk_i), .q(rxclk_s));

    rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_dat_sync (
        .clk(clk), .rst(rst), .d(rxd_i), .q(rxd_s));

    rx_framer u_framer (
        .clk(clk), .rst(rst), .rxclk_s(rxclk_s), .rxd_s(rxd_s), .mode_i(mode),
        .done_o(done), .char_o(char_w), .perr_o(perr), .ferr_o(ferr));

    rx_host_port u_host (
        .clk(clk), .rst(rst), .cmd_sel_i(cmd_sel_i), .rd_n_i(rd_n_i),
        .wr_n_i(wr_n_i), .wdata_i(wdata_i), .done_i(done), .char_i(char_w),
        .perr_i(perr), .ferr_i(ferr), .mode_o(mode), .rdata_o(rdata_o),
        .ready_o(ready_o));
endmodule

// File: tb/serial_rx_unit_test.sv
`timescale 1ns/1ps
module serial_rx_unit_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_clk = 1'b0, rxd = 1'b1, cmd_sel = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic ready;
    logic [7:0] snap;
    int checks = 0, fails = 0;

    always #10 clk = ~clk;

    serial_rx_unit uut (
        .clk(clk), .rst(rst), .rx_clk_i(rx_clk), .rxd_i(rxd), .cmd_sel_i(cmd_sel),
        .rd_n_i(rd_n), .wr_n_i(wr_n), .wdata_i(wdata), .rdata_o(rdata), .ready_o(ready));

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_read(input logic sel, output logic [7:0] v);
        @(negedge clk); cmd_sel = sel; rd_n = 1'b0; #1 v = rdata;
        @(negedge clk); rd_n = 1'b1;
    endtask

    task automatic host_write(input logic sel, input logic [7:0] d);
        @(negedge clk); cmd_sel = sel; wdata = d; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1;
    endtask

    task automatic tick(input logic v, input logic rd);
        @(negedge clk); rxd = v; rx_clk = 1'b0;
        @(negedge clk);
        @(negedge clk); rx_clk = 1'b1;
        @(negedge clk);
        @(negedge clk);
        if (rd) begin
            cmd_sel = 1'b0; rd_n = 1'b0; #1 snap = rdata;
            @(negedge clk); rd_n = 1'b1;
        end
    endtask

    function automatic logic [7:0] mode_word(input int f, input int len, input int pm);
        logic [1:0] fc;
        fc = (f == 1) ? 2'b00 : ((f == 16) ? 2'b01 : 2'b10);
        return {2'b00, (pm == 2), (pm != 0), 2'(len - 5), fc};
    endfunction

    task automatic send_frame(input logic [7:0] d, input int len, input int pm,
                              input logic bad_par, input logic bad_stop,
                              input int f, input logic rd_stop);
        int mid;
        logic p;
        mid = (f == 1) ? 0 : f / 2;
        p = 1'b0;
        for (int b = 0; b < len; b++) p = p ^ d[b];
        if (pm == 1) p = ~p;
        for (int i = 0; i < f; i++) tick(1'b0, 1'b0);
        for (int b = 0; b < len; b++)
            for (int i = 0; i < f; i++) tick(d[b], 1'b0);
        if (pm != 0)
            for (int i = 0; i < f; i++) tick(p ^ bad_par, 1'b0);
        for (int i = 0; i < f; i++) tick(~bad_stop, rd_stop && (i == mid));
        for (int i = 0; i < f + 2; i++) tick(1'b1, 1'b0);
    endtask

    task automatic expect_char(input string tag, input logic [7:0] ed, input logic [7:0] es);
        logic [7:0] v;
        host_read(1'b1, v); chk({tag, " status"}, v, es);
        host_read(0, v);    chk({tag, " data"}, v, ed);
        chk({tag, " ready cleared"}, {7'b0, ready}, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v, mask, d;
        logic [7:0] pats [4];
        pats[0] = 8'hA5; pats[1] = 8'h5A; pats[2] = 8'hFF; pats[3] = 8'h31;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        @(negedge clk); chk("R1 ready", {7'b0, ready}, 8'h00);
        host_read(1'b1, v); chk("R1 status", v, 8'h00);
        host_read(1'b0, v); chk("R1 data", v, 8'h00);

        // R2 R4 R7 sweep: factor x length x parity mode
        foreach (pats[k]) begin
            for (int len = 5; len <= 8; len++) begin
                for (int pm = 0; pm < 3; pm++) begin
                    mask = 8'((1 << len) - 1);
                    host_write(1'b1, mode_word(1, len, pm));
                    send_frame(pats[k], len, pm, 1'b0, 1'b0, 1, 1'b0);
                    expect_char("R2 R4 x1", pats[k] & mask, 8'h01);
                end
            end
        end
        for (int len = 5; len <= 8; len++) begin
            for (int pm = 0; pm < 3; pm++) begin
                d = 8'(8'h96 + len * 7 + pm);
                mask = 8'((1 << len) - 1);
                host_write(1'b1, mode_word(16, len, pm));
                send_frame(d, len, pm, 1'b0, 1'b0, 16, 1'b0);
                expect_char("R2 R4 R7 x16", d & mask, 8'h01);
            end
        end
        host_write(1'b1, mode_word(64, 8, 2));
        send_frame(8'hC3, 8, 2, 1'b0, 1'b0, 64, 1'b0);
        expect_char("R2 x64 len8 even", 8'hC3, 8'h01);
        host_write(1'b1, mode_word(64, 5, 0));
        send_frame(8'h16, 5, 0, 1'b0, 1'b0, 64, 1'b0);
        expect_char("R2 x64 len5", 8'h16, 8'h01);

        // R3 start glitch at 64x and 16x
        for (int i = 0; i < 30; i++) tick(1'b0, 1'b0);
        for (int i = 0; i < 70; i++) tick(1'b1, 1'b0);
        chk("R3 glitch x64 no char", {7'b0, ready}, 8'h00);
        host_write(1'b1, mode_word(16, 8, 1));
        for (int i = 0; i < 7; i++) tick(1'b0, 1'b0);
        for (int i = 0; i < 20; i++) tick(1'b1, 1'b0);
        chk("R3 glitch x16 no char", {7'b0, ready}, 8'h00);

        // R7 parity error, R12 sticky across good char, R11 clear
        send_frame(8'h4E, 8, 1, 1'b1, 1'b0, 16, 1'b0);
        expect_char("R7 parity error", 8'h4E, 8'h03);
        send_frame(8'h11, 8, 1, 1'b0, 1'b0, 16, 1'b0);
        expect_char("R12 sticky parity", 8'h11, 8'h03);
        host_write(1'b1, 8'hC0);
        host_read(1'b1, v); chk("R11 clear parity", v, 8'h00);

        // R8 framing error, char delivered
        send_frame(8'h7D, 8, 1, 1'b0, 1'b1, 16, 1'b0);
        expect_char("R8 framing", 8'h7D, 8'h09);
        host_write(1'b1, 8'hC0);

        // R9 overrun, R6 status read keeps ready, R11 clear keeps ready and buffer
        send_frame(8'h21, 8, 1, 1'b0, 1'b0, 16, 1'b0);
        host_read(1'b1, v); chk("R6 status read keeps ready", v, 8'h01);
        chk("R6 ready still set", {7'b0, ready}, 8'h01);
        send_frame(8'h42, 8, 1, 1'b0, 1'b0, 16, 1'b0);
        host_read(1'b1, v); chk("R9 overrun status", v, 8'h05);
        host_write(1'b1, 8'hC0);
        host_read(1'b1, v); chk("R11 clear keeps ready", v, 8'h01);
        host_write(1'b0, 8'hEE);
        host_read(1'b1, v); chk("R11 data write ignored status", v, 8'h01);
        expect_char("R9 new char replaced", 8'h42, 8'h01);

        // R10 R5 read coinciding with completion
        send_frame(8'hA1, 8, 1, 1'b0, 1'b0, 16, 1'b0);
        send_frame(8'h3C, 8, 1, 1'b0, 1'b0, 16, 1'b1);
        chk("R5 held char during collision", snap, 8'hA1);
        chk("R10 ready stays", {7'b0, ready}, 8'h01);
        expect_char("R10 no overrun, new char", 8'h3C, 8'h01);

        // R13 status layout with all flags
        host_write(1'b1, mode_word(1, 6, 2));
        send_frame(8'h15, 6, 2, 1'b1, 1'b1, 1, 1'b0);
        send_frame(8'h2A, 6, 2, 1'b0, 1'b0, 1, 1'b0);
        expect_char("R13 all flags", 8'h2A, 8'h0F);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule